// File: doc/BRIEF.md
# Event-to-Interrupt Routing Controller

This block takes 128 system event lines and delivers them to fourteen outputs: twelve maskable CPU interrupt lines (interrupts 4 to 15), an exception line and a debug-event line. Each output has its own 7-bit selector register that names which event drives it. When the selected event rises, the output gives a one-cycle pulse. Several event numbers are reserved and are held at zero inside the block.

Four combiners each gather a 32-event group into a set of sticky flags. A combiner output is the OR of the flags that its mask register leaves enabled. Combiner outputs occupy event numbers 0 to 3, so a combined event can be routed like any other event.

A CPU interrupt stays pending from its pulse until the CPU acknowledges it. If its selected event rises again while it is still pending, that occurrence is lost. The block records the loss in a status register and raises internal event 96 for one cycle. A separate qualifier accepts a falling edge on the active-low NMI pin only when both the high level before it and the low level after it have lasted a minimum number of clock cycles.

Top module: `intr_router`

## Requirements
- R1: Out of reset, every selector reads 4, which is a reserved event. Every combiner mask reads all ones, and no output pulses.
- R2: Selector addresses 0 to 11 choose the event for CPU interrupts 4 to 15 (`cpu_int` bits 0 to 11). Address 12 chooses the event for `exc_out` and address 13 the event for `dbg_out`. A rising edge of the selected event produces a pulse on that output in the next cycle, and the pulse lasts exactly one cycle even if the event stays high.
- R3: Any event number from 0 to 127 can be selected for any output, including 127.
- R4: Combiner g latches event 32g+i into flag bit i. Flag bit 0 of combiner 0 is never set. The combined event g is the OR of the flags whose bit in mask register 16+g is 0 (1 means masked). A raw event reaches an output routed to event g two cycles after the raw event rises. Clearing a mask bit over a flag that is already latched raises event g.
- R5: Flag register 20+g reads the latched flags. A flag stays set after its event falls. Writing 1 to a bit of that address clears the bit, unless the event is still high in that cycle.
- R6: A CPU interrupt is pending from its pulse until the matching `int_ack` bit is high for one cycle. If the selected event rises again while the interrupt is pending and not acknowledged, there is no pulse. Instead, bit k of the drop status at address 24 is set and event 96 rises one cycle later.
- R7: Drop status bits stay set until software writes 1 to them at address 24.
- R8: After an acknowledge, the next rising edge of the selected event produces a pulse again.
- R9: The input lines for events 0 to 3, 96, 4 to 8 and 98 to 99 have no effect on any output.
- R10: A falling edge of `nmi_n` produces one `nmi_out` pulse only when the high level before it lasted at least NMI_MIN (6) cycles and the low level after it also lasts at least NMI_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 128 | System event lines |
| int_ack | input | 12 | Per-interrupt acknowledge from the CPU |
| nmi_n | input | 1 | External non-maskable interrupt pin, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| cpu_int | output | 12 | Pulses for CPU interrupts 4 to 15 |
| exc_out | output | 1 | Exception pulse |
| dbg_out | output | 1 | Debug-event pulse |
| nmi_out | output | 1 | Qualified NMI pulse |

## Verification
The hardest situation to reach from the ports is a dropped interrupt, because event 96 is generated inside the block and has no input line of its own. The stimulus first routes event 50 to an interrupt and lets it pend. It then routes event 96 to the debug output, lowers event 50 and raises it again without an acknowledge. The scoreboard expects no interrupt pulse in the next cycle and a debug pulse in the cycle after that. Re-raising a combined event is reached in a similar way: a flag is latched while its mask bit is set, and the mask bit is then cleared.

// File: rtl/intr_pkg.sv
// Package: shared sizes, register addresses and the reserved-event mask
// for the event router. Assumes 128 events in groups of 32.
package intr_pkg;
    localparam int NUM_EVT     = 128;
    localparam int NUM_CPU_INT = 12;
    localparam int NUM_SLOT    = NUM_CPU_INT + 2;
    localparam int GRP_W       = 32;
    localparam int NUM_GRP     = NUM_EVT / GRP_W;
    localparam int SEL_W       = $clog2(NUM_EVT);
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 32;
    localparam int DROP_EVT    = 96;
    localparam int PARK_EVT    = 4;
    localparam int A_SEL0      = 0;
    localparam int A_MASK0     = 16;
    localparam int A_FLAG0     = 20;
    localparam int A_DROP      = 24;

    // Events whose input lines are not connected and must read as zero.
    function automatic logic [NUM_EVT-1:0] rsv_mask();
        logic [NUM_EVT-1:0] m;
        m = '0;
        for (int i = 4; i <= 8; i++) m[i] = 1'b1;
        m[98] = 1'b1;
        m[99] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/intr_combiner.sv
// Combiner: keeps one sticky flag per event of a group and ORs the unmasked
// flags into one combined event. A set in the same cycle wins over a clear.
module intr_combiner #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags,
    output logic         comb
);
    // Latch incoming events and apply write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | evt;
    end

    // Combined event from the enabled flags.
    assign comb = |(flags & ~mask);
endmodule

// File: rtl/intr_route_slot.sv
// Route slot: selects one event's rising edge and pulses for one cycle.
// The output pends until acknowledged. An edge that arrives while the output
// is pending and not acknowledged is reported on drop and gives no pulse.
// For an output without acknowledge, tie ack high.
module intr_route_slot #(
    parameter int EVT_W = 128,
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [EVT_W-1:0] rise,
    input  logic             ack,
    output logic             pulse,
    output logic             drop
);
    logic hit, pend, deliver;

    // Edge of the selected event, and the deliver/drop decision.
    always_comb begin
        hit     = rise[sel];
        deliver = hit && (!pend || ack);
        drop    = hit && pend && !ack;
    end

    // Output pulse and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            pend  <= 1'b0;
        end else begin
            pulse <= deliver;
            if (deliver)  pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_nmi_qual.sv
// NMI qualifier: synchronises the active-low pin and emits one pulse when a
// low level that followed a high level of at least MIN cycles has itself
// lasted MIN cycles. The pin is assumed idle high.
module intr_nmi_qual #(
    parameter int MIN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    output logic nmi_out
);
    localparam int CNT_W = $clog2(MIN + 1);

    logic             s1, s2, lvl_prev, armed;
    logic [CNT_W-1:0] cnt;

    // Two-stage synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= nmi_n;
            s2 <= s1;
        end
    end

    // Measure run lengths, arm on a qualified fall, fire once per low level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b1;
            cnt      <= '0;
            armed    <= 1'b0;
            nmi_out  <= 1'b0;
        end else begin
            lvl_prev <= s2;
            nmi_out  <= 1'b0;
            if (s2 != lvl_prev) begin
                cnt   <= CNT_W'(1);
                armed <= !s2 && (cnt >= CNT_W'(MIN));
            end else begin
                if (cnt < CNT_W'(MIN)) cnt <= cnt + CNT_W'(1);
                if (!s2 && armed && cnt == CNT_W'(MIN - 1)) begin
                    nmi_out <= 1'b1;
                    armed   <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/intr_router.sv
// Event router top: holds the selector, mask and drop-status registers and
// builds the effective event vector. Combiner outputs replace events 0..3,
// the drop event replaces 96 and reserved lines are forced low. Rising edges
// of that vector feed fourteen route slots. Register reads are combinational.
module intr_router
    import intr_pkg::*;
#(
    parameter int NMI_MIN = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EVT-1:0]     evt_in,
    input  logic [NUM_CPU_INT-1:0] int_ack,
    input  logic                   nmi_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [NUM_CPU_INT-1:0] cpu_int,
    output logic                   exc_out,
    output logic                   dbg_out,
    output logic                   nmi_out
);
    localparam logic [NUM_EVT-1:0] RSV = rsv_mask();

    logic [SEL_W-1:0]    sel_q     [NUM_SLOT];
    logic [GRP_W-1:0]    mask_q    [NUM_GRP];
    logic [GRP_W-1:0]    cmb_flags [NUM_GRP];
    logic [GRP_W-1:0]    clr_v     [NUM_GRP];
    logic [GRP_W-1:0]    grp_in    [NUM_GRP];
    logic [NUM_GRP-1:0]  cmb_out;
    logic [NUM_EVT-1:0]  eff_evt, evt_prev, evt_rise;
    logic [NUM_SLOT-1:0] slot_pulse, slot_ack, drop_vec, drop_status;
    logic                drop_pulse;

    // Effective event vector with internal sources and reserved lines applied.
    always_comb begin
        eff_evt                = evt_in & ~RSV;
        eff_evt[NUM_GRP-1:0]   = cmb_out;
        eff_evt[DROP_EVT]      = drop_pulse;
        evt_rise               = eff_evt & ~evt_prev;
    end

    // Group slices for the combiners; combiner 0 never sees its own output.
    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_in[g] = eff_evt[g*GRP_W +: GRP_W];
            clr_v[g]  = (reg_we && reg_addr == ADDR_W'(A_FLAG0 + g)) ? reg_wdata[GRP_W-1:0] : '0;
        end
        grp_in[0][0] = 1'b0;
    end

    // Previous effective events for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= '0;
        else        evt_prev <= eff_evt;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_cmb
        intr_combiner #(.W(GRP_W)) u_cmb (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (grp_in[g]),
            .mask  (mask_q[g]),
            .clr   (clr_v[g]),
            .flags (cmb_flags[g]),
            .comb  (cmb_out[g])
        );
    end

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
        if (k < NUM_CPU_INT) begin : g_ack
            assign slot_ack[k] = int_ack[k];
        end else begin : g_noack
            assign slot_ack[k] = 1'b1;
        end
        intr_route_slot #(.EVT_W(NUM_EVT), .SEL_W(SEL_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel_q[k]),
            .rise  (evt_rise),
            .ack   (slot_ack[k]),
            .pulse (slot_pulse[k]),
            .drop  (drop_vec[k])
        );
    end

    assign cpu_int = slot_pulse[NUM_CPU_INT-1:0];
    assign exc_out = slot_pulse[NUM_CPU_INT];
    assign dbg_out = slot_pulse[NUM_CPU_INT+1];

    // Register writes, drop status and the one-cycle drop event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SLOT; k++) sel_q[k] <= SEL_W'(PARK_EVT);
            for (int g = 0; g < NUM_GRP; g++) mask_q[g] <= '1;
            drop_status <= '0;
            drop_pulse  <= 1'b0;
        end else begin
            drop_pulse <= |drop_vec;
            if (reg_we && reg_addr == ADDR_W'(A_DROP))
                drop_status <= (drop_status & ~reg_wdata[NUM_SLOT-1:0]) | drop_vec;
            else
                drop_status <= drop_status | drop_vec;
            if (reg_we) begin
                for (int k = 0; k < NUM_SLOT; k++)
                    if (reg_addr == ADDR_W'(A_SEL0 + k)) sel_q[k] <= reg_wdata[SEL_W-1:0];
                for (int g = 0; g < NUM_GRP; g++)
                    if (reg_addr == ADDR_W'(A_MASK0 + g)) mask_q[g] <= reg_wdata[GRP_W-1:0];
            end
        end
    end

    // Combinational register read.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_SLOT; k++)
            if (reg_addr == ADDR_W'(A_SEL0 + k)) reg_rdata = DATA_W'(sel_q[k]);
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr == ADDR_W'(A_MASK0 + g)) reg_rdata = DATA_W'(mask_q[g]);
            if (reg_addr == ADDR_W'(A_FLAG0 + g)) reg_rdata = DATA_W'(cmb_flags[g]);
        end
        if (reg_addr == ADDR_W'(A_DROP)) reg_rdata = DATA_W'(drop_status);
    end

    intr_nmi_qual #(.MIN(NMI_MIN)) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .nmi_out (nmi_out)
    );
endmodule

// File: rtl/intr_router_chk.sv
// Checker: temporal properties of the event router, bound to the top module.
module intr_router_chk
    import intr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CPU_INT-1:0] cpu_int,
    input logic                   exc_out,
    input logic                   dbg_out,
    input logic                   nmi_out,
    input logic [NUM_SLOT-1:0]    drop_vec,
    input logic                   drop_pulse,
    input logic [4:0]             rsv_flags
);
    // R1: nothing fires in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cpu_int == '0 && !exc_out && !dbg_out));

    // R2: a CPU interrupt pulse never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_int & $past(cpu_int)) == '0);

    // R6: a drop is followed by the internal drop event.
    a_r6_drop_raises_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (|drop_vec) |=> drop_pulse);

    // R9: reserved event lines never reach the combiner flags.
    a_r9_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_flags == '0);

    // R10: one qualified NMI gives a single-cycle pulse.
    a_r10_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |=> !nmi_out);
endmodule

bind intr_router intr_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_int    (cpu_int),
    .exc_out    (exc_out),
    .dbg_out    (dbg_out),
    .nmi_out    (nmi_out),
    .drop_vec   (drop_vec),
    .drop_pulse (drop_pulse),
    .rsv_flags  (cmb_flags[0][8:4])
);

// File: tb/intr_router_test.sv
// Scoreboard bench: drivers queue expected output states by cycle and a
// monitor compares them after each rising edge.
module intr_router_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_in = '0;
    logic [11:0]  int_ack = '0;
    logic         nmi_n = 1'b1;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [11:0]  cpu_int;
    logic         exc_out, dbg_out, nmi_out;

    typedef struct {
        int          cyc;
        string       req;
        logic [13:0] val;
    } item_t;

    item_t q[$];
    item_t it;
    int    cyc = 0;
    int    compared = 0;
    int    mismatched = 0;
    int    nmi_seen = 0;
    bit    done = 0;

    always #4 clk = ~clk;

    intr_router uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .int_ack(int_ack), .nmi_n(nmi_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_int(cpu_int), .exc_out(exc_out), .dbg_out(dbg_out), .nmi_out(nmi_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Queue the expected {cpu_int, exc, dbg} state lat cycles from now.
    task automatic expect_at(input int lat, input string req, input logic [11:0] ci,
                             input logic ex, input logic db);
        item_t e;
        e.cyc = cyc + lat;
        e.req = req;
        e.val = {ci, ex, db};
        q.push_back(e);
    endtask

    // Monitor: sample after each edge and compare due items.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        if (nmi_out) nmi_seen++;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            chk(it.req, {18'd0, cpu_int, exc_out, dbg_out}, {18'd0, it.val});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic ack(input logic [11:0] m);
        @(negedge clk);
        int_ack = m;
        @(negedge clk);
        int_ack = '0;
    endtask

    task automatic nmi_level(input logic v, input int n);
        @(negedge clk);
        nmi_n = v;
        tick(n - 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 outputs", {19'd0, cpu_int, exc_out}, 32'd0);
        rd("R1 selector", 5'd0, 32'd4);
        rd("R1 mask", 5'd18, 32'hFFFF_FFFF);
        tick(20);  // NMI pin stays high long enough to qualify later

        // R2 routing to CPU, exception and debug outputs
        wr(5'd0, 32'd10);
        wr(5'd12, 32'd20);
        wr(5'd13, 32'd33);
        @(negedge clk); evt_in[10] = 1'b1;
        expect_at(1, "R2 cpu pulse", 12'h001, 1'b0, 1'b0);
        expect_at(2, "R2 one cycle", 12'h000, 1'b0, 1'b0);
        tick(3);
        @(negedge clk); evt_in[20] = 1'b1;
        expect_at(1, "R2 exc pulse", 12'h000, 1'b1, 1'b0);
        expect_at(2, "R2 exc one cycle", 12'h000, 1'b0, 1'b0);
        tick(3);
        @(negedge clk); evt_in[33] = 1'b1;
        expect_at(1, "R2 dbg pulse", 12'h000, 1'b0, 1'b1);
        tick(3);
        ack('1);
        evt_in = '0;

        // R3 highest event number
        wr(5'd11, 32'd127);
        @(negedge clk); evt_in[127] = 1'b1;
        expect_at(1, "R3 event 127", 12'h800, 1'b0, 1'b0);
        tick(3);
        evt_in = '0;
        ack('1);

        // R4/R5 combiner 0
        wr(5'd20, 32'hFFFF_FFFF);
        wr(5'd1, 32'd0);
        wr(5'd16, ~32'h0000_0400);
        ack('1);
        @(negedge clk); evt_in[10] = 1'b1;
        expect_at(1, "R4 raw first", 12'h001, 1'b0, 1'b0);
        expect_at(2, "R4 combined", 12'h002, 1'b0, 1'b0);
        tick(3);
        evt_in[10] = 1'b0;
        rd("R5 flag persists", 5'd20, 32'h0000_0400);
        ack('1);
        @(negedge clk); evt_in[11] = 1'b1;
        expect_at(1, "R4 masked quiet", 12'h000, 1'b0, 1'b0);
        expect_at(2, "R4 masked quiet", 12'h000, 1'b0, 1'b0);
        tick(3);
        evt_in[11] = 1'b0;
        rd("R5 flags", 5'd20, 32'h0000_0C00);
        wr(5'd20, 32'h0000_0400);
        rd("R5 w1c one bit", 5'd20, 32'h0000_0800);
        wr(5'd16, ~32'h0000_0C00);
        expect_at(1, "R4 unmask raises", 12'h002, 1'b0, 1'b0);
        tick(3);
        wr(5'd20, 32'h0000_0800);
        rd("R5 cleared", 5'd20, 32'h0000_0000);
        ack('1);

        // R6/R7/R8 pending and drop
        wr(5'd2, 32'd50);
        wr(5'd13, 32'd96);
        @(negedge clk); evt_in[50] = 1'b1;
        expect_at(1, "R6 first delivery", 12'h004, 1'b0, 1'b0);
        tick(2);
        evt_in[50] = 1'b0;
        tick(2);
        @(negedge clk); evt_in[50] = 1'b1;
        expect_at(1, "R6 no pulse when pending", 12'h000, 1'b0, 1'b0);
        expect_at(2, "R6 drop event 96", 12'h000, 1'b0, 1'b1);
        tick(3);
        rd("R6 drop status", 5'd24, 32'h0000_0004);
        tick(3);
        rd("R7 status sticky", 5'd24, 32'h0000_0004);
        wr(5'd24, 32'h0000_0004);
        rd("R7 status cleared", 5'd24, 32'h0000_0000);
        evt_in[50] = 1'b0;
        ack(12'h004);
        @(negedge clk); evt_in[50] = 1'b1;
        expect_at(1, "R8 after ack", 12'h004, 1'b0, 1'b0);
        tick(3);
        evt_in = '0;
        ack('1);

        // R9 ignored input lines
        wr(5'd3, 32'd5);
        wr(5'd4, 32'd0);
        wr(5'd5, 32'd98);
        wr(5'd12, 32'd2);
        @(negedge clk);
        evt_in[5] = 1'b1; evt_in[96] = 1'b1; evt_in[0] = 1'b1;
        evt_in[98] = 1'b1; evt_in[2] = 1'b1;
        expect_at(1, "R9 ignored", 12'h000, 1'b0, 1'b0);
        expect_at(2, "R9 ignored", 12'h000, 1'b0, 1'b0);
        expect_at(3, "R9 ignored", 12'h000, 1'b0, 1'b0);
        tick(4);
        rd("R9 drop status unchanged", 5'd24, 32'h0000_0000);
        evt_in = '0;

        // R10 NMI qualification
        n0 = nmi_seen;
        nmi_level(1'b0, 3);
        nmi_level(1'b1, 12);
        chk("R10 short low rejected", nmi_seen - n0, 0);
        n0 = nmi_seen;
        nmi_level(1'b0, 12);
        nmi_level(1'b1, 12);
        chk("R10 long low accepted once", nmi_seen - n0, 1);
        n0 = nmi_seen;
        nmi_level(1'b1, 3);
        nmi_level(1'b0, 12);
        nmi_level(1'b1, 3);
        nmi_level(1'b0, 12);
        nmi_level(1'b1, 12);
        chk("R10 short high rejected", nmi_seen - n0, 1);

        tick(3);
        chk("scoreboard drained", q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule